// File: doc/BRIEF.md
# I2C Register Bank Target

This block is the serial-bus front end of a bank of 8-bit control registers. It watches an open-drain two-wire bus (clock line and data line, each seen as an input and driven only by pulling low) and answers at one fixed 7-bit target address. A write frame carries a register index followed by any number of data bytes, which land in consecutive registers. A read frame returns register contents MSB first, advancing through the bank one register per byte.

Both lines are resampled on the system clock through a synchronizer and a majority-vote filter. START and STOP are recognised from the filtered lines. The register bank sits outside the block. It is reached through a write strobe with address and data, and through a read-data input that is sampled at the address the block presents.

An index byte followed by a repeated START and a read header returns data from that index. A read header after a STOP returns data from register zero.

Top module: `i2c_regbank_target`

## Requirements
- R1: The 7-bit target address is the upper seven bits of the first byte after START, and bit 0 is the direction (0 write, 1 read). When the address matches, the block pulls the data line low during the ninth clock of that byte.
- R2: When the address does not match, the block drives no acknowledge and performs no register write. It stays silent until the next START or STOP. A repeated START carrying the correct address is answered normally.
- R3: In a write frame, the byte after the address byte sets the register pointer. Each following data byte is acknowledged and written with one single-cycle strobe. The pointer then advances by one.
- R4: A write frame holding only a register index, followed by a repeated START and a read header, returns the register at that index.
- R5: In a read frame, each byte is sent MSB first, and the pointer advances after every byte sent. A continuous frame can therefore read the whole bank in order.
- R6: A STOP clears the pointer to 0, so a read frame that begins after a STOP starts at register 0.
- R7: A not-acknowledge from the controller after a read byte ends transmission. The block releases the data line and stays released until the next START or STOP.
- R8: When the pointer advances from the highest implemented register (NUM_REGS-1) or from any higher index, it wraps to 0.
- R9: A write to an index at or above NUM_REGS is acknowledged but produces no write strobe. A read from such an index returns 0x00, whatever the bank's read-data input carries.
- R10: The data-line drive changes only after a falling clock edge, and never while the clock line is high.
- R11: While reset is held and just after it is released, the data line is released and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| reg_addr | output | 8 | Register index for the write strobe and for read data |
| reg_wdata | output | 8 | Write data, valid with reg_we |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_rdata | input | 8 | Bank contents at reg_addr |

## Verification
A pointer left stale by a STOP, or advanced at the wrong point, shows up as the wrong byte on the very next read frame. An off-by-one in the bit counter shows up within one byte: the acknowledge slot moves, the controller samples a high data line where it expects a low one, and the transmitted bytes come out shifted. A wrong address match or a missing release shows as a low data line seen by the controller in a slot it owns, in the same bit period. A write strobe issued out of range or in the wrong state only surfaces on a later sequential read of the whole bank. For that reason the bench ends with a full-bank read compared against its own model.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RX_ADDR,
    ST_ACK_ADDR,
    ST_RX_REG,
    ST_ACK_REG,
    ST_RX_DATA,
    ST_ACK_DATA,
    ST_TX_DATA,
    ST_RX_ACK,
    ST_IGNORE
  } rb_state_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_rb_filter.sv
module i2c_rb_filter #(
  parameter int STAGES = 2,
  parameter int TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int HALF = TAPS / 2;

  logic [STAGES-1:0] sync_q;
  logic [TAPS-1:0]   win_q;
  logic              vote;

  assign vote = ($countones(win_q) > HALF);

  // Lines idle high, so every stage resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      win_q  <= {win_q[TAPS-2:0], sync_q[STAGES-1]};
      dout   <= vote;
    end
  end
endmodule

// File: rtl/i2c_rb_ptr.sv
module i2c_rb_ptr #(
  parameter int AW       = 8,
  parameter int NUM_REGS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr,
  output logic          in_range
);
  localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);

  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr)       ptr_d = '0;
    else if (load) ptr_d = load_val;
    else if (inc)  ptr_d = (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr      = ptr_q;
  assign in_range = (ptr_q <= LAST);
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h2A,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_TAPS   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  localparam int         AW       = 8;
  localparam logic [3:0] RX_LAST  = 4'(BYTE_W);
  localparam logic [3:0] TX_LAST  = 4'(BYTE_W - 1);

  // ---------------- line conditioning ----------------
  logic [1:0] line_raw, line_f;
  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_rb_filter #(.STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (line_raw[g]),
      .dout (line_f[g])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = line_f[1];
  assign sda_f = line_f[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  =  scl_f & ~scl_q;
  assign scl_fall  = ~scl_f &  scl_q;
  assign start_det =  scl_f &  scl_q &  sda_q & ~sda_f;
  assign stop_det  =  scl_f &  scl_q & ~sda_q &  sda_f;

  // ---------------- pointer ----------------
  logic          ptr_clr, ptr_load, ptr_inc, ptr_ok;
  logic [AW-1:0] ptr;

  i2c_rb_ptr #(.AW(AW), .NUM_REGS(NUM_REGS)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ptr_clr),
    .load    (ptr_load),
    .load_val(shreg_q),
    .inc     (ptr_inc),
    .ptr     (ptr),
    .in_range(ptr_ok)
  );

  // ---------------- protocol state ----------------
  rb_state_t  state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] shreg_q, shreg_d;
  logic [7:0] txsh_q, txsh_d;
  logic       rw_q, rw_d;
  logic       acked_q, acked_d;
  logic       oe_q, oe_d;
  logic [7:0] rd_byte;

  assign rd_byte = ptr_ok ? reg_rdata : 8'h00;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    txsh_d   = txsh_q;
    rw_d     = rw_q;
    acked_d  = acked_q;
    oe_d     = oe_q;
    ptr_clr  = 1'b0;
    ptr_load = 1'b0;
    ptr_inc  = 1'b0;
    reg_we   = 1'b0;

    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      ptr_clr = 1'b1;
    end else if (start_det) begin
      state_d = ST_RX_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX_ADDR, ST_RX_REG, ST_RX_DATA: begin
          if (scl_rise) begin
            shreg_d = {shreg_q[6:0], sda_f};
            cnt_d   = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == RX_LAST) begin
            cnt_d = '0;
            if (state_q == ST_RX_ADDR) begin
              if (shreg_q[7:1] == TARGET_ADDR) begin
                rw_d    = shreg_q[0];
                oe_d    = 1'b1;
                state_d = ST_ACK_ADDR;
              end else begin
                state_d = ST_IGNORE;
              end
            end else if (state_q == ST_RX_REG) begin
              ptr_load = 1'b1;
              oe_d     = 1'b1;
              state_d  = ST_ACK_REG;
            end else begin
              reg_we  = ptr_ok;
              ptr_inc = 1'b1;
              oe_d    = 1'b1;
              state_d = ST_ACK_DATA;
            end
          end
        end
        ST_ACK_ADDR: begin
          if (scl_fall) begin
            if (rw_q) begin
              txsh_d  = rd_byte;
              oe_d    = ~rd_byte[7];
              cnt_d   = '0;
              state_d = ST_TX_DATA;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_RX_REG;
            end
          end
        end
        ST_ACK_REG, ST_ACK_DATA: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_RX_DATA;
          end
        end
        ST_TX_DATA: begin
          if (scl_fall) begin
            if (cnt_q == TX_LAST) begin
              oe_d    = 1'b0;
              ptr_inc = 1'b1;
              state_d = ST_RX_ACK;
            end else begin
              txsh_d = {txsh_q[6:0], 1'b0};
              oe_d   = ~txsh_q[6];
              cnt_d  = cnt_q + 1'b1;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_rise) begin
            acked_d = ~sda_f;
          end else if (scl_fall) begin
            if (acked_q) begin
              txsh_d  = rd_byte;
              oe_d    = ~rd_byte[7];
              cnt_d   = '0;
              state_d = ST_TX_DATA;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      txsh_q  <= '0;
      rw_q    <= 1'b0;
      acked_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      txsh_q  <= txsh_d;
      rw_q    <= rw_d;
      acked_q <= acked_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr;
  assign reg_wdata = shreg_q;
endmodule

// File: rtl/i2c_rb_chk.sv
module i2c_rb_chk
  import i2c_rb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int AW       = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          scl_fall,
  input logic          start_det,
  input logic          stop_det,
  input rb_state_t     state
);
  localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);

  // R10
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall | start_det | stop_det));

  // R3
  we_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_addr == (($past(reg_addr) >= LAST) ? '0 : $past(reg_addr) + 1'b1)));

  // R3
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R9
  we_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_addr <= LAST));

  // R6
  stop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (reg_addr == '0));

  // R2
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> (!sda_oe && !reg_we));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);
endmodule

bind i2c_regbank_target i2c_rb_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .scl_fall (scl_fall),
  .start_det(start_det),
  .stop_det (stop_det),
  .state    (state_q)
);

// File: tb/i2c_regbank_target_bench.sv
module i2c_regbank_target_bench;
  localparam logic [6:0] TADDR = 7'h2A;
  localparam int         NREG  = 16;
  localparam int         Q     = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       scl_drv;
  logic       ctl_low;
  logic       sda_line;
  logic       sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  logic [7:0] bank  [NREG];
  logic [7:0] exp_m [NREG];
  logic [7:0] tx_buf[NREG];
  logic [7:0] rx_buf[NREG];

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  int  mon_bad = 0;
  logic oe_prev;

  assign sda_line  = ~(ctl_low | sda_oe);
  assign reg_rdata = (reg_addr < 8'(NREG)) ? bank[reg_addr[3:0]] : 8'hEE;

  i2c_regbank_target u_i2c_regbank_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_drv),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_we   (reg_we),
    .reg_rdata(reg_rdata)
  );

  // Bench-side register bank behind the write port.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= 8'hA0 + 8'(i);
    end else if (reg_we && reg_addr < 8'(NREG)) begin
      bank[reg_addr[3:0]] <= reg_wdata;
    end
  end

  // R10: drive may not change while the clock line is high.
  always @(posedge clk) begin
    if (rst_n && scl_drv && (sda_oe !== oe_prev)) mon_bad++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, expv);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    ctl_low = 1'b0; wait_q();
    scl_drv = 1'b1; wait_q();
    ctl_low = 1'b1; wait_q();
    scl_drv = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    ctl_low = 1'b1; wait_q();
    scl_drv = 1'b1; wait_q();
    ctl_low = 1'b0; wait_q(); wait_q();
  endtask

  task automatic send_bit(input logic b);
    ctl_low = ~b; wait_q();
    scl_drv = 1'b1; wait_q(); wait_q();
    scl_drv = 1'b0; wait_q();
  endtask

  task automatic recv_bit(output logic b);
    ctl_low = 1'b0; wait_q();
    scl_drv = 1'b1; wait_q();
    b = sda_line; wait_q();
    scl_drv = 1'b0; wait_q();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~ack);
  endtask

  // Write n bytes from tx_buf starting at register ra; model update and ACK checks.
  task automatic wr_at(input string req, input logic [7:0] ra, input int n);
    logic a;
    logic [7:0] p;
    bus_start();
    wbyte({TADDR, 1'b0}, a); chk({req, " addr ack"}, 8'(a), 8'h01);
    wbyte(ra, a);            chk({req, " index ack"}, 8'(a), 8'h01);
    p = ra;
    for (int i = 0; i < n; i++) begin
      wbyte(tx_buf[i], a);   chk({req, " data ack"}, 8'(a), 8'h01);
      if (p < 8'(NREG)) exp_m[p[3:0]] = tx_buf[i];
      p = (p >= 8'(NREG - 1)) ? 8'h00 : p + 8'h01;
    end
    bus_stop();
  endtask

  // Preset index, repeated START, read n bytes into rx_buf.
  task automatic rd_at(input string req, input logic [7:0] ra, input int n);
    logic a;
    bus_start();
    wbyte({TADDR, 1'b0}, a); chk({req, " addr ack"}, 8'(a), 8'h01);
    wbyte(ra, a);            chk({req, " index ack"}, 8'(a), 8'h01);
    bus_start();
    wbyte({TADDR, 1'b1}, a); chk({req, " read hdr ack"}, 8'(a), 8'h01);
    for (int i = 0; i < n; i++) rbyte(i != n - 1, rx_buf[i]);
    bus_stop();
  endtask

  // Read n bytes with no preset (frame opens after STOP).
  task automatic rd_plain(input string req, input int n);
    logic a;
    bus_start();
    wbyte({TADDR, 1'b1}, a); chk({req, " read hdr ack"}, 8'(a), 8'h01);
    for (int i = 0; i < n; i++) rbyte(i != n - 1, rx_buf[i]);
    bus_stop();
  endtask

  // kind (0 write, 1 read-compare), register index, value
  localparam logic [17:0] VEC [9] = '{
    {2'd0, 8'h02, 8'h5A},
    {2'd0, 8'h03, 8'hC3},
    {2'd1, 8'h02, 8'h5A},
    {2'd1, 8'h03, 8'hC3},
    {2'd0, 8'h00, 8'h11},
    {2'd1, 8'h00, 8'h11},
    {2'd0, 8'h0F, 8'h7E},
    {2'd1, 8'h0F, 8'h7E},
    {2'd1, 8'h01, 8'hA1}
  };

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    rst_n = 1'b0; scl_drv = 1'b1; ctl_low = 1'b0;
    for (int i = 0; i < NREG; i++) exp_m[i] = 8'hA0 + 8'(i);
    repeat (5) @(negedge clk);
    chk("R11 drive in reset", 8'(sda_oe), 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 drive after reset", 8'(sda_oe), 8'h00);

    // R11 / R6: first read after reset starts at register 0
    rd_plain("R11", 1);
    chk("R11 first read", rx_buf[0], exp_m[0]);

    // Vector table: R1 acks, R3 writes, R4 preset reads
    for (int v = 0; v < 9; v++) begin
      if (VEC[v][17:16] == 2'd0) begin
        tx_buf[0] = VEC[v][7:0];
        wr_at("R3", VEC[v][15:8], 1);
      end else begin
        rd_at("R4", VEC[v][15:8], 1);
        chk("R4 preset read", rx_buf[0], VEC[v][7:0]);
      end
    end

    // R3 multi-byte write, R5 sequential read MSB first
    tx_buf[0] = 8'h81; tx_buf[1] = 8'h42; tx_buf[2] = 8'h24; tx_buf[3] = 8'h18;
    wr_at("R3 burst", 8'h04, 4);
    rd_at("R5", 8'h04, 4);
    for (int i = 0; i < 4; i++) chk("R5 burst read", rx_buf[i], exp_m[4 + i]);

    // R6: preset then STOP; next read starts at 0
    bus_start();
    wbyte({TADDR, 1'b0}, a); chk("R6 addr ack", 8'(a), 8'h01);
    wbyte(8'h09, a);         chk("R6 index ack", 8'(a), 8'h01);
    bus_stop();
    rd_plain("R6", 1);
    chk("R6 read after stop", rx_buf[0], exp_m[0]);

    // R8 wrap on write and on read
    tx_buf[0] = 8'h3C; tx_buf[1] = 8'h4D; tx_buf[2] = 8'h5E;
    wr_at("R8 write wrap", 8'h0E, 3);
    chk("R8 reg0 written by wrap", exp_m[0], 8'h5E);
    rd_at("R8", 8'h0F, 2);
    chk("R8 last reg", rx_buf[0], 8'h4D);
    chk("R8 wrapped to reg0", rx_buf[1], 8'h5E);

    // R9 out-of-range index
    tx_buf[0] = 8'h55;
    wr_at("R9 write", 8'h20, 1);
    rd_at("R9", 8'h20, 1);
    chk("R9 read out of range", rx_buf[0], 8'h00);

    // R2 mismatched address, then repeated START with the right one
    bus_start();
    wbyte({7'h2B, 1'b0}, a); chk("R2 no ack on address", 8'(a), 8'h00);
    wbyte(8'h03, a);         chk("R2 no ack on index", 8'(a), 8'h00);
    wbyte(8'hEE, a);         chk("R2 no ack on data", 8'(a), 8'h00);
    bus_start();
    wbyte({TADDR, 1'b1}, a); chk("R2 ack after restart", 8'(a), 8'h01);
    rbyte(1'b0, d);          chk("R2 read after restart", d, exp_m[0]);
    bus_stop();
    rd_at("R2", 8'h03, 1);
    chk("R2 reg3 untouched", rx_buf[0], exp_m[3]);

    // R7 NACK releases the line
    bus_start();
    wbyte({TADDR, 1'b0}, a); chk("R7 addr ack", 8'(a), 8'h01);
    wbyte(8'h05, a);         chk("R7 index ack", 8'(a), 8'h01);
    bus_start();
    wbyte({TADDR, 1'b1}, a); chk("R7 read hdr ack", 8'(a), 8'h01);
    rbyte(1'b0, d);          chk("R7 last byte", d, exp_m[5]);
    rbyte(1'b0, d);          chk("R7 line released after nack", d, 8'hFF);
    bus_stop();

    // R5 / R9: whole bank in one frame, no stray writes
    rd_plain("R5 full", NREG);
    for (int i = 0; i < NREG; i++) chk("R5 full bank read", rx_buf[i], exp_m[i]);

    chk("R10 drive stable while clock high", 8'(mon_bad), 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule